// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block produces the fixed 32-bit answer that a memory card returns when its reset pin is pulsed. It samples the card reset pin and the card serial clock in the core clock domain. When a reset pulse ends and at least one rising serial-clock edge fell inside that pulse, the block starts driving the answer bit by bit onto the card data line. Each later falling serial-clock edge moves it on to the next bit. After the last bit it releases the line and returns to standby.

The answer word is a parameter. Stream bit k is bit k of that word, so byte 0 sits in bits 7:0 and each byte leaves least significant bit first. A pulse that contains no clock edge aborts to standby. A pulse that ends while a nonvolatile write is in progress is ignored. A power-fail input aborts the answer at once. The card reset and card clock inputs are assumed to be already synchronous to `clk`.

Top module: `atr_serializer`

## Requirements
- R1: After `rst_n` is low at a clock edge, `dout_oe` and `dout` are both 0.
- R2: Stream bit k equals `RESP_WORD[k]`. The default word is 32'h55AA4119, which sends bytes 19h, 41h, AAh and 55h in that order, each least significant bit first.
- R3: If a rising `card_clk` edge is sampled while `card_rst` is high and `wr_busy` is low when the pulse end is sampled, then from the next cycle on `dout_oe` is 1 and `dout` carries stream bit 0.
- R4: While sending with `card_rst` low, each sampled falling `card_clk` edge advances the output by one bit. With no such edge, the bit and `dout_oe` hold.
- R5: The falling edge that follows bit 31 sets `dout_oe` and `dout` to 0. Further clocks do not restart the answer.
- R6: A reset pulse with no rising `card_clk` edge inside it leaves the block in standby (`dout_oe` = 0). This holds whether the block was idle or in mid-answer.
- R7: A reset pulse that contains a clock edge, issued in mid-answer, restarts the output at stream bit 0.
- R8: If `wr_busy` is high when the end of the reset pulse is sampled, no answer starts and `dout_oe` goes or stays 0.
- R9: `pwr_fail` high at a clock edge forces `dout_oe` and `dout` to 0 from the next cycle on.
- R10: While `card_rst` is high in mid-answer, falling `card_clk` edges do not advance the bit. The current bit stays on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_rst | input | 1 | Card reset pin level |
| card_clk | input | 1 | Card serial clock level |
| wr_busy | input | 1 | Nonvolatile write in progress |
| pwr_fail | input | 1 | Power interruption, aborts the answer |
| dout | output | 1 | Serial answer bit, 0 when released |
| dout_oe | output | 1 | Enable for the three-state data pin |

## Verification
The bench picks stream positions where neighbouring bits differ. A restart that skips bit 0 is then visible, and so is a pulse whose inner clock fall wrongly advances the bit. Both would show the wrong level on `dout`. It walks past bit 31 and keeps clocking, which catches a counter that wraps into a second answer instead of releasing the line. It also drives a clockless pulse in mid-answer, a pulse with the write-busy flag set, and a power failure. A design that treated every pulse end alike, ignored the busy flag or missed the abort would keep `dout_oe` high in those cases.

// File: rtl/atr_pkg.sv
// Package: shared types and defaults for the answer-to-reset serializer.
// Assumes nothing beyond a single core clock domain.
package atr_pkg;
    typedef enum logic {
        ATR_IDLE = 1'b0,
        ATR_SEND = 1'b1
    } atr_state_e;

    // Default answer, byte 0 in the low bits: 19h 41h AAh 55h.
    localparam logic [31:0] ATR_DEFAULT_WORD = 32'h55AA_4119;
endpackage

// File: rtl/atr_edge_det.sv
// Module: single-level edge detector.
// Reports rise/fall of `sig` in the cycle the new level is first seen.
// Assumes `sig` is already synchronous to `clk`.
module atr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Compare current level against the remembered one.
    always_comb begin
        rise = sig & ~prev_q;
        fall = ~sig & prev_q;
    end
endmodule

// File: rtl/atr_pulse_mon.sv
// Module: reset-pulse monitor.
// Tracks whether a rising serial-clock edge fell inside the current card
// reset pulse and flags the cycle in which that pulse ends.
// Assumes edge inputs come from atr_edge_det on the same clock.
module atr_pulse_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_level,
    input  logic rst_rise,
    input  logic rst_fall,
    input  logic sclk_rise,
    input  logic pwr_fail,
    output logic pulse_end,
    output logic clk_inside
);
    logic seen_q;

    // Record a clock edge seen while the reset pin is high.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_fail)       seen_q <= 1'b0;
        else if (rst_rise)            seen_q <= sclk_rise;
        else if (rst_level && sclk_rise) seen_q <= 1'b1;
    end

    // Publish pulse end and memory of an inner clock.
    always_comb begin
        pulse_end  = rst_fall;
        clk_inside = seen_q;
    end

    // R3
    seen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_level && sclk_rise && !pwr_fail) |=> clk_inside);

    // R6
    seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_rise && !sclk_rise) |=> !clk_inside);
endmodule

// File: rtl/atr_bit_seq.sv
// Module: answer sequencer.
// Holds the send state and bit index, selects the outgoing bit from the
// parameter word, and applies the start, restart, abort and busy rules.
// Assumes pulse_end and clk_inside come from atr_pulse_mon.
module atr_bit_seq
    import atr_pkg::*;
#(
    parameter int          NBITS     = 32,
    parameter logic [NBITS-1:0] RESP_WORD = ATR_DEFAULT_WORD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_end,
    input  logic clk_inside,
    input  logic wr_busy,
    input  logic pwr_fail,
    input  logic rst_level,
    input  logic sclk_fall,
    output logic dout,
    output logic dout_oe
);
    localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

    atr_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             shift_en;

    // Advance only on a falling clock outside a reset pulse.
    always_comb shift_en = sclk_fall & ~rst_level;

    // State and index update with abort, pulse-end and shift rules.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_fail) begin
            state_q <= ATR_IDLE;
            idx_q   <= '0;
        end else if (pulse_end) begin
            idx_q   <= '0;
            state_q <= (clk_inside && !wr_busy) ? ATR_SEND : ATR_IDLE;
        end else if (state_q == ATR_SEND && shift_en) begin
            if (idx_q == LAST_IDX) begin
                state_q <= ATR_IDLE;
                idx_q   <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Drive the selected bit, forced low when released.
    always_comb begin
        dout_oe = (state_q == ATR_SEND);
        dout    = dout_oe & RESP_WORD[idx_q];
    end

    // R9
    pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !dout_oe);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_end && wr_busy) |=> !dout_oe);

    // R6
    noclk_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_end && !clk_inside) |=> !dout_oe);

    // R3
    start_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_end && clk_inside && !wr_busy && !pwr_fail)
        |=> (dout_oe && idx_q == '0));

    // R4
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !sclk_fall && !pulse_end && !pwr_fail)
        |=> (dout_oe && $stable(idx_q)));

    // R5
    release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && idx_q == LAST_IDX && shift_en && !pulse_end && !pwr_fail)
        |=> !dout_oe);
endmodule

// File: rtl/atr_serializer.sv
// Module: top of the synchronous answer-to-reset serializer.
// Detects card reset and clock edges, watches for a clock inside each
// reset pulse and hands the result to the sequencer that drives the pin.
// Assumes card_rst and card_clk are already synchronous to clk.
module atr_serializer
    import atr_pkg::*;
#(
    parameter int          NBITS     = 32,
    parameter logic [NBITS-1:0] RESP_WORD = ATR_DEFAULT_WORD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic card_clk,
    input  logic wr_busy,
    input  logic pwr_fail,
    output logic dout,
    output logic dout_oe
);
    logic rst_rise, rst_fall;
    logic sclk_rise, sclk_fall;
    logic pulse_end, clk_inside;

    atr_edge_det u_rst_edge (
        .clk (clk), .rst_n (rst_n), .sig (card_rst),
        .rise (rst_rise), .fall (rst_fall)
    );

    atr_edge_det u_clk_edge (
        .clk (clk), .rst_n (rst_n), .sig (card_clk),
        .rise (sclk_rise), .fall (sclk_fall)
    );

    atr_pulse_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_level  (card_rst),
        .rst_rise   (rst_rise),
        .rst_fall   (rst_fall),
        .sclk_rise  (sclk_rise),
        .pwr_fail   (pwr_fail),
        .pulse_end  (pulse_end),
        .clk_inside (clk_inside)
    );

    atr_bit_seq #(.NBITS (NBITS), .RESP_WORD (RESP_WORD)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_end  (pulse_end),
        .clk_inside (clk_inside),
        .wr_busy    (wr_busy),
        .pwr_fail   (pwr_fail),
        .rst_level  (card_rst),
        .sclk_fall  (sclk_fall),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );
endmodule

// File: tb/sim_atr_serializer.sv
module sim_atr_serializer;
    localparam int CLK_P = 10;
    localparam logic [31:0] EXP_WORD = 32'h55AA_4119;

    // Entry: {busy, clocks after start[5:0], exp_oe, exp_dout}
    localparam int NVEC = 11;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 6'd0,  1'b1, 1'b1},
        {1'b0, 6'd1,  1'b1, 1'b0},
        {1'b0, 6'd3,  1'b1, 1'b1},
        {1'b0, 6'd8,  1'b1, 1'b1},
        {1'b0, 6'd16, 1'b1, 1'b0},
        {1'b0, 6'd17, 1'b1, 1'b1},
        {1'b0, 6'd30, 1'b1, 1'b1},
        {1'b0, 6'd31, 1'b1, 1'b0},
        {1'b0, 6'd32, 1'b0, 1'b0},
        {1'b1, 6'd0,  1'b0, 1'b0},
        {1'b1, 6'd2,  1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0, card_clk = 1'b0, wr_busy = 1'b0, pwr_fail = 1'b0;
    logic dout, dout_oe;
    int   n_run = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    atr_serializer u0 (
        .clk (clk), .rst_n (rst_n), .card_rst (card_rst), .card_clk (card_clk),
        .wr_busy (wr_busy), .pwr_fail (pwr_fail), .dout (dout), .dout_oe (dout_oe)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sclk_pulse();
        card_clk = 1'b1; step();
        card_clk = 1'b0; step();
    endtask

    task automatic rst_pulse(input logic with_clk, input logic busy);
        wr_busy  = busy;
        card_rst = 1'b1; step();
        if (with_clk) sclk_pulse();
        card_rst = 1'b0; step();
        wr_busy  = 1'b0;
    endtask

    task automatic chk(input string req, input logic exp_oe, input logic exp_d);
        n_run++;
        if (dout_oe !== exp_oe || dout !== exp_d) begin
            n_fail++;
            $display("FAIL %s: oe=%b dout=%b expected oe=%b dout=%b",
                     req, dout_oe, dout, exp_oe, exp_d);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 reset state", 1'b0, 1'b0);
        rst_n = 1'b1; step();
        chk("R1 idle after reset", 1'b0, 1'b0);

        // Table walk: R2 bit positions, R3 start, R5 end, R8 busy.
        for (int v = 0; v < NVEC; v++) begin
            rst_pulse(1'b1, VEC[v][8]);
            for (int c = 0; c < int'(VEC[v][7:2]); c++) sclk_pulse();
            chk("R2/R3/R5/R8 table", VEC[v][1], VEC[v][0]);
        end

        // R2: full stream, then R5 release and no restart.
        rst_pulse(1'b1, 1'b0);
        for (int k = 0; k < 32; k++) begin
            chk("R2 stream bit", 1'b1, EXP_WORD[k]);
            sclk_pulse();
        end
        chk("R5 released after bit 31", 1'b0, 1'b0);
        sclk_pulse(); sclk_pulse();
        chk("R5 no restart on later clocks", 1'b0, 1'b0);

        // R4: hold without clock edges.
        rst_pulse(1'b1, 1'b0);
        sclk_pulse();
        for (int w = 0; w < 5; w++) step();
        chk("R4 hold bit1", 1'b1, 1'b0);
        sclk_pulse(); sclk_pulse();
        chk("R4 advance to bit3", 1'b1, 1'b1);

        // R10 and R7: clock inside pulse at bit 2, then restart.
        rst_pulse(1'b1, 1'b0);
        sclk_pulse(); sclk_pulse();
        card_rst = 1'b1; step();
        sclk_pulse();
        chk("R10 bit held during pulse", 1'b1, 1'b0);
        card_rst = 1'b0; step();
        chk("R7 restart at bit0", 1'b1, 1'b1);
        sclk_pulse();
        chk("R7 restart continues bit1", 1'b1, 1'b0);

        // R6: clockless pulse in mid-answer, then from standby.
        sclk_pulse(); sclk_pulse();
        chk("R6 precheck bit3", 1'b1, 1'b1);
        rst_pulse(1'b0, 1'b0);
        chk("R6 abort mid-answer", 1'b0, 1'b0);
        sclk_pulse();
        chk("R6 stays in standby", 1'b0, 1'b0);
        rst_pulse(1'b0, 1'b0);
        chk("R6 clockless from standby", 1'b0, 1'b0);

        // R8: busy pulse in mid-answer.
        rst_pulse(1'b1, 1'b0);
        sclk_pulse();
        rst_pulse(1'b1, 1'b1);
        chk("R8 busy pulse ends answer", 1'b0, 1'b0);

        // R9: power failure in mid-answer.
        rst_pulse(1'b1, 1'b0);
        sclk_pulse(); sclk_pulse(); sclk_pulse();
        pwr_fail = 1'b1; step();
        chk("R9 power fail abort", 1'b0, 1'b0);
        pwr_fail = 1'b0;
        sclk_pulse();
        chk("R9 stays released", 1'b0, 1'b0);

        // R1: reset in mid-answer.
        rst_pulse(1'b1, 1'b0);
        rst_n = 1'b0; step();
        chk("R1 reset mid-answer", 1'b0, 1'b0);
        rst_n = 1'b1; step();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule